// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Read View

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of week, date, month, year and century. It advances once on each single-cycle pulse of a one-per-second tick input. Two copies of the time exist. The live counters advance on every tick unless the stop bit is set. A second copy, the one the bus sees, is reloaded from the live counters on each tick. Both copies change on the same clock edge, so a bus read never returns a set of fields that is only partly updated.

Software reaches eight byte registers through a small bus with an address, write data, and read and write strobes. To take a consistent reading, software sets the freeze bit in the control register. The bus view then holds the count from the moment the bit was written, while the live counters keep advancing underneath. After the bit is cleared, the next tick brings the view back to the live count. A stop bit in the seconds register halts all counting. The stop bit is set after reset, so the clock starts out stopped.

A bus write to a time field changes the live counter at once. The new value appears in the bus view at the next tick. Spare bits in the time registers are plain storage and read back as soon as they are written.

Top module: `rtc_calendar_snap`

## Requirements
- R1: After reset, reads return control 0x00, seconds 0x80 (the stop bit is set and the seconds are zero), minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Register offsets are fixed: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year. The time fields sit in the low bits in BCD: seconds and minutes in bits 6:0, hours and date in bits 5:0, weekday in bits 2:0, month in bits 4:0, year in bits 7:0, century in control bits 5:0.
- R3: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00, and each field counts in BCD.
- R4: When the hours roll over, the weekday advances and wraps from 07 to 01.
- R5: When the hours roll over, the date advances and returns to 01 after the last day of the month. The last day is 30 for months 04, 06, 09 and 11. It is 29 for month 02 when the year is divisible by 4, and 28 for month 02 otherwise. For all other months it is 31.
- R6: Month rolls from 12 to 01 and advances the year. Year rolls from 99 to 00 and advances the century. Century rolls from 39 to 00.
- R7: Seconds-register bit 7 is the stop bit. While it is 1, ticks do not change the count. Writing 0 to it makes the next tick advance the count again.
- R8: Control bit 6 is the freeze bit. Writing it to 1 loads the bus view with the live count at that moment. While it stays 1, the bus view holds that value and the live count keeps advancing.
- R9: After the freeze bit is cleared, the first tick loads the bus view with the live count.
- R10: A bus write to a time field updates the live count, and the bus view shows the new value after the next tick. The spare bits read back as written, straight away. These are control bit 7, minutes bit 7, hours bits 7:6, weekday bits 7:3, date bits 7:6 and month bits 7:5.
- R11: The read data output is 0x00 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | Single-cycle pulse, one per second |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from the offset |

## Verification
A wrong carry or month-length decision in the live counters shows up at the ports one tick later, and only when the view is not frozen. A single bad rollover then stays in every later reading. So each directed boundary case checks all eight registers immediately after its one tick. A freeze that captures the wrong instant shows as soon as the first read after the freeze bit is set. A release that fails to resync shows on the read after the first tick that follows the clear. Random times, each advanced over a few ticks, are compared with an integer calendar model kept inside the bench.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int REG_COUNT = 8;
    localparam int REG_AW    = $clog2(REG_COUNT);
    localparam int REG_DW    = 8;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL  = 3'd0,
        REG_SEC   = 3'd1,
        REG_MIN   = 3'd2,
        REG_HOUR  = 3'd3,
        REG_DOW   = 3'd4,
        REG_DATE  = 3'd5,
        REG_MONTH = 3'd6,
        REG_YEAR  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [5:0] cent;
        logic [7:0] year;
        logic [4:0] month;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic       wbit;
        logic       rbit;
        logic       osc_stop;
        logic       min_x;
        logic [1:0] hour_x;
        logic [4:0] dow_x;
        logic [1:0] date_x;
        logic [2:0] month_x;
    } side_bits_t;

    localparam cal_time_t CAL_RESET = '{
        cent: 6'h00, year: 8'h00, month: 5'h01, date: 6'h01,
        dow: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00
    };

    localparam side_bits_t SIDE_RESET = '{
        wbit: 1'b0, rbit: 1'b0, osc_stop: 1'b1, min_x: 1'b0,
        hour_x: 2'b00, dow_x: 5'b0, date_x: 2'b00, month_x: 3'b000
    };

    // Add one to a two-digit packed BCD value.
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Divisible by 4: (10*tens + ones) mod 4 == (2*tens + ones) mod 4.
    function automatic logic year_is_leap(input logic [7:0] y);
        logic [4:0] s;
        s = {y[6:4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [5:0] month_last_day(input logic [4:0] m,
                                                   input logic       leap);
        logic [5:0] d;
        case (m)
            5'h02:                      d = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
            default:                    d = 6'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_time_advance.sv
module rtc_time_advance
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  cal_time_t cur,
    output cal_time_t nxt
);

    logic [7:0] t_sec, t_min, t_hour, t_date, t_month, t_year, t_cent;
    logic [5:0] last_day;

    always_comb begin
        t_sec    = bcd_step({1'b0, cur.sec});
        t_min    = bcd_step({1'b0, cur.min});
        t_hour   = bcd_step({2'b00, cur.hour});
        t_date   = bcd_step({2'b00, cur.date});
        t_month  = bcd_step({3'b000, cur.month});
        t_year   = bcd_step(cur.year);
        t_cent   = bcd_step({2'b00, cur.cent});
        last_day = month_last_day(cur.month, year_is_leap(cur.year));
    end

    always_comb begin
        nxt = cur;
        if (en) begin
            if (cur.sec != 7'h59) begin
                nxt.sec = t_sec[6:0];
            end else begin
                nxt.sec = 7'h00;
                if (cur.min != 7'h59) begin
                    nxt.min = t_min[6:0];
                end else begin
                    nxt.min = 7'h00;
                    if (cur.hour != 6'h23) begin
                        nxt.hour = t_hour[5:0];
                    end else begin
                        nxt.hour = 6'h00;
                        nxt.dow  = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
                        if (cur.date < last_day) begin
                            nxt.date = t_date[5:0];
                        end else begin
                            nxt.date = 6'h01;
                            if (cur.month != 5'h12) begin
                                nxt.month = t_month[4:0];
                            end else begin
                                nxt.month = 5'h01;
                                if (cur.year != 8'h99) begin
                                    nxt.year = t_year;
                                end else begin
                                    nxt.year = 8'h00;
                                    nxt.cent = (cur.cent == 6'h39) ? 6'h00 : t_cent[5:0];
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    AST_SEC_WRAP_CARRY: assert property (@(posedge clk) disable iff (rst)
        (en && cur.sec == 7'h59) |-> (nxt.sec == 7'h00 && nxt.min != cur.min)); // R3
    AST_DOW_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (en && cur.dow >= 3'd1 && cur.dow <= 3'd7) |-> (nxt.dow >= 3'd1 && nxt.dow <= 3'd7)); // R4
    AST_DATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (en && cur.date != 6'h00) |-> (nxt.date != 6'h00)); // R5

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      freeze,
    input  logic      capture,
    input  cal_time_t live_now,
    input  cal_time_t live_next,
    output cal_time_t view
);

    always_ff @(posedge clk) begin
        if (rst)                  view <= CAL_RESET;
        else if (capture)         view <= live_now;
        else if (tick && !freeze) view <= live_next;
    end

    AST_FROZEN_VIEW: assert property (@(posedge clk) disable iff (rst)
        (freeze && $past(freeze)) |-> $stable(view)); // R8

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_cal_pkg::*;
(
    input  logic              rd,
    input  logic [REG_AW-1:0] addr,
    input  side_bits_t        side,
    input  cal_time_t         view,
    output logic [REG_DW-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (reg_sel_e'(addr))
                REG_CTRL:  rdata = {side.wbit, side.rbit, view.cent};
                REG_SEC:   rdata = {side.osc_stop, view.sec};
                REG_MIN:   rdata = {side.min_x, view.min};
                REG_HOUR:  rdata = {side.hour_x, view.hour};
                REG_DOW:   rdata = {side.dow_x, view.dow};
                REG_DATE:  rdata = {side.date_x, view.date};
                REG_MONTH: rdata = {side.month_x, view.month};
                REG_YEAR:  rdata = view.year;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtc_calendar_snap.sv
module rtc_calendar_snap
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [REG_DW-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [REG_DW-1:0] bus_rdata
);

    cal_time_t  live_q, live_adv, live_d, view;
    side_bits_t side_q, side_d;
    logic       adv_en, capture;

    assign adv_en  = tick_1hz && !side_q.osc_stop;
    assign capture = bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL)
                     && bus_wdata[6] && !side_q.rbit;

    rtc_time_advance u_adv (
        .clk (clk),
        .rst (rst),
        .en  (adv_en),
        .cur (live_q),
        .nxt (live_adv)
    );

    // Bus writes land on top of this cycle's advanced value.
    always_comb begin
        live_d = live_adv;
        side_d = side_q;
        if (bus_wr) begin
            case (reg_sel_e'(bus_addr))
                REG_CTRL: begin
                    side_d.wbit = bus_wdata[7];
                    side_d.rbit = bus_wdata[6];
                    live_d.cent = bus_wdata[5:0];
                end
                REG_SEC: begin
                    side_d.osc_stop = bus_wdata[7];
                    live_d.sec      = bus_wdata[6:0];
                end
                REG_MIN: begin
                    side_d.min_x = bus_wdata[7];
                    live_d.min   = bus_wdata[6:0];
                end
                REG_HOUR: begin
                    side_d.hour_x = bus_wdata[7:6];
                    live_d.hour   = bus_wdata[5:0];
                end
                REG_DOW: begin
                    side_d.dow_x = bus_wdata[7:3];
                    live_d.dow   = bus_wdata[2:0];
                end
                REG_DATE: begin
                    side_d.date_x = bus_wdata[7:6];
                    live_d.date   = bus_wdata[5:0];
                end
                REG_MONTH: begin
                    side_d.month_x = bus_wdata[7:5];
                    live_d.month   = bus_wdata[4:0];
                end
                REG_YEAR: live_d.year = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= CAL_RESET;
            side_q <= SIDE_RESET;
        end else begin
            live_q <= live_d;
            side_q <= side_d;
        end
    end

    rtc_snapshot u_snap (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_1hz),
        .freeze    (side_q.rbit),
        .capture   (capture),
        .live_now  (live_q),
        .live_next (live_adv),
        .view      (view)
    );

    rtc_read_mux u_rmux (
        .rd    (bus_rd),
        .addr  (bus_addr),
        .side  (side_q),
        .view  (view),
        .rdata (bus_rdata)
    );

    AST_STOPPED_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (side_q.osc_stop && !bus_wr) |=> $stable(live_q)); // R7
    AST_REFRESH_TRACKS_LIVE: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !side_q.rbit && !bus_wr) |=> (view == live_q)); // R9

endmodule

// File: tb/rtc_calendar_snap_tb_top.sv
module rtc_calendar_snap_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // index by register offset: 0 cent,1 sec,2 min,3 hour,4 dow,5 date,6 month,7 year
    int tm [8];
    int snap [8];

    always #5 clk = ~clk;

    rtc_calendar_snap dut_i (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        tm[1]++;
        if (tm[1] == 60) begin
            tm[1] = 0; tm[2]++;
            if (tm[2] == 60) begin
                tm[2] = 0; tm[3]++;
                if (tm[3] == 24) begin
                    tm[3] = 0;
                    tm[4] = (tm[4] == 7) ? 1 : tm[4] + 1;
                    tm[5]++;
                    if (tm[5] > mdays(tm[6], tm[7])) begin
                        tm[5] = 1; tm[6]++;
                        if (tm[6] == 13) begin
                            tm[6] = 1; tm[7]++;
                            if (tm[7] == 100) begin
                                tm[7] = 0;
                                tm[0] = (tm[0] == 39) ? 0 : tm[0] + 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 3'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk);
    endtask

    // compare all registers with a given time array; rbit is the expected freeze bit
    task automatic check_regs(input string req, input int t [8], input bit rbit);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(i, d);
            if (i == 0) check(req, d, {1'b0, rbit, 6'(to_bcd(t[0]))});
            else        check(req, d, to_bcd(t[i]));
        end
    endtask

    // load tm into the clock, leave it running (stop bit cleared)
    task automatic load_time();
        wr(1, 8'h80 | to_bcd(tm[1]));
        for (int i = 2; i < 8; i++) wr(i, to_bcd(tm[i]));
        wr(0, {2'b00, 6'(to_bcd(tm[0]))});
        wr(1, to_bcd(tm[1]));
    endtask

    task automatic set_tm(input int c, input int y, input int mo, input int da,
                          input int dw, input int h, input int mi, input int s);
        tm[0] = c; tm[7] = y; tm[6] = mo; tm[5] = da;
        tm[4] = dw; tm[3] = h; tm[2] = mi; tm[1] = s;
    endtask

    task automatic directed(input string req, input int c, input int y, input int mo,
                            input int da, input int dw, input int h, input int mi, input int s);
        set_tm(c, y, mo, da, dw, h, mi, s);
        load_time();
        tick();
        model_step();
        check_regs(req, tm, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240229));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd(0, d); check("R1 ctrl", d, 8'h00);
        rd(1, d); check("R1 sec", d, 8'h80);
        rd(2, d); check("R1 min", d, 8'h00);
        rd(3, d); check("R1 hour", d, 8'h00);
        rd(4, d); check("R1 dow", d, 8'h01);
        rd(5, d); check("R1 date", d, 8'h01);
        rd(6, d); check("R1 month", d, 8'h01);
        rd(7, d); check("R1 year", d, 8'h00);

        // R11 idle read data
        bus_addr = 3'd1; #1; check("R11 idle", bus_rdata, 8'h00);

        // R7 stopped at reset: tick changes nothing
        tick();
        rd(1, d); check("R7 stopped", d, 8'h80);

        // R2/R3 distinct fields and minute carry
        directed("R3 min carry", 20, 24, 7, 15, 3, 9, 59, 59);
        directed("R2 map", 12, 34, 11, 27, 5, 18, 42, 7);
        // R4/R5 non-leap February end, weekday wrap
        directed("R5 feb28", 20, 23, 2, 28, 7, 23, 59, 59);
        // R5 leap
        directed("R5 leap29", 20, 24, 2, 28, 2, 23, 59, 59);
        directed("R5 leapend", 20, 24, 2, 29, 3, 23, 59, 59);
        directed("R5 apr30", 20, 25, 4, 30, 6, 23, 59, 59);
        directed("R4 dowwrap", 20, 25, 5, 30, 7, 23, 59, 59);
        // R6 year and century rollover
        directed("R6 yearwrap", 20, 99, 12, 31, 4, 23, 59, 59);
        directed("R6 centwrap", 39, 99, 12, 31, 1, 23, 59, 59);

        // random times, a few ticks each
        for (int k = 0; k < 30; k++) begin
            int n;
            set_tm($urandom % 40, $urandom % 100, 1 + $urandom % 12, 1, 1 + $urandom % 7,
                   $urandom % 24, 55 + $urandom % 5, 55 + $urandom % 5);
            tm[5] = 1 + $urandom % mdays(tm[6], tm[7]);
            if (k % 3 == 0) begin tm[3] = 23; tm[5] = mdays(tm[6], tm[7]); end
            load_time();
            n = 1 + $urandom % 5;
            for (int j = 0; j < n; j++) begin tick(); model_step(); end
            check_regs("R3 random", tm, 1'b0);
        end

        // R7 stop and resume
        set_tm(20, 10, 3, 3, 3, 3, 3, 3);
        load_time();
        wr(1, 8'h83);
        tick(); tick(); tick();
        rd(1, d); check("R7 hold", d, 8'h83);
        wr(1, 8'h03);
        tick(); model_step();
        rd(1, d); check("R7 resume", d, 8'h04);

        // R8 freeze captures instant, live keeps going
        wr(0, {2'b01, 6'(to_bcd(tm[0]))});
        snap = tm;
        for (int j = 0; j < 3; j++) begin tick(); model_step(); end
        check_regs("R8 frozen", snap, 1'b1);
        // R9 release: view unchanged until the next tick
        wr(0, {2'b00, 6'(to_bcd(tm[0]))});
        rd(1, d); check("R9 before tick", d, to_bcd(snap[1]));
        tick(); model_step();
        check_regs("R9 resync", tm, 1'b0);

        // R10 spare bits and deferred field view
        wr(1, 8'h80 | to_bcd(tm[1]));
        wr(2, 8'hC5);
        rd(2, d); check("R10 spare now", d, {1'b1, 7'(to_bcd(tm[2]))});
        wr(4, 8'hF9);
        rd(4, d); check("R10 dow spare", d, {5'b11111, 3'(to_bcd(tm[4]))});
        tick();
        rd(2, d); check("R10 min after tick", d, 8'hC5);
        rd(4, d); check("R10 dow after tick", d, 8'hF9);
        wr(6, 8'hE9);
        rd(6, d); check("R10 month spare", d, {3'b111, 5'(to_bcd(tm[6]))});
        wr(0, 8'h80 | {2'b00, 6'(to_bcd(tm[0]))});
        rd(0, d); check("R10 ctrl wbit", d, {2'b10, 6'(to_bcd(tm[0]))});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule